// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the control state for a windowed general register file: a window base pointer that selects which group of four physical registers acts as logical register 0, and a live-frame bitmask with one bit per group. It maps the sixteen logical register numbers onto the physical file, with wraparound. It also carries out the window side of function call entry, windowed return, relative rotation, direct base writes, restoring the base after a window trap, and the stack-pointer move check.

Each command is presented with `cmd_valid_i`. Its results appear on registered outputs after the next rising clock edge. Those results are a stack-pointer write request, a return PC, or a single exception request. A window overflow or underflow exception also reports the base value the trap handler must save, and asks for the exception-mode bit to be set. The processor status fields that the checks need (window-enable, exception mode, saved base) arrive as inputs. Vectoring to the handler happens outside this block.

Top module: `wreg_ctrl`

## Requirements
- R1: After reset, the window base is 0, the live mask has only bit 0 set, and every registered output is idle: no exception (code 0), no stack write, no return valid, no exception-mode request.
- R2: The physical index for logical register i is (base*4 + i) mod NAREG. A base write (op 4) loads the base from `wb_val_i`.
- R3: An entry (op 1) raises illegal-instruction (code 1) and changes no state when the stack specifier exceeds 3, when window-enable is clear, or when exception mode is set.
- R4: A legal entry whose checked mask bits are clear does four things. It requests a write of sp - imm to logical register callinc*4 + spec[1:0], with the index taken in the old window. It advances the base by callinc. It sets the mask bit at the new base. It raises no exception.
- R5: A legal entry with any mask bit set at base+1 .. base+callinc raises an overflow. The base advances to the first set bit above it. The old base is reported, and exception mode is requested. The code is 2, 3 or 4 (sizes 4, 8 or 12) when the next set bit beyond is 0, 1, or 2 or more groups further on. The mask is unchanged.
- R6: A return (op 2) raises illegal-instruction (code 1) and changes no state in four cases: when n = a0[31:30] is 0; when the nearest set mask bit among base-1, base-2, base-3 lies at distance m != n; when window-enable is clear; or when exception mode is set.
- R7: A legal return whose mask bit at base-n is set moves the base down by n and clears the old base's mask bit. It also presents return PC = {pc[31:30], a0[29:0]} with return-valid.
- R8: A legal return whose mask bit at base-n is clear still moves the base down by n. It raises underflow code 5, 6 or 7 for n = 1, 2 or 3, reports the old base, requests exception mode, and leaves the mask and return-valid untouched.
- R9: The stack-pointer move check (op 6) raises alloca (code 8) when the mask bits at base-1, base-2 and base-3 are all clear. Otherwise it reports nothing. It never changes state.
- R10: Rotate (op 3) adds the signed 4-bit `rot_i` to the base modulo NAREG/4. Restore (op 5) loads the base from `ps_owb_i`.
- R11: Every command's outputs are valid for exactly the cycle after it is accepted. At most one of exception, stack write and return-valid is active. An idle cycle, or op 0 or 7, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | 1 entry, 2 return, 3 rotate, 4 base write, 5 restore, 6 stack move check |
| ps_woe_i | input | 1 | Window-enable status bit |
| ps_excm_i | input | 1 | Exception-mode status bit |
| ps_owb_i | input | WB_W | Saved base, used by restore |
| callinc_i | input | 2 | Call increment for entry |
| spec_i | input | 4 | Stack register specifier for entry |
| imm_i | input | 32 | Frame size subtracted from sp on entry |
| sp_i | input | 32 | Current stack pointer value |
| a0_i | input | 32 | Logical register 0 value for return |
| pc_hi_i | input | 2 | Top two bits of the current PC |
| rot_i | input | 4 | Signed rotate amount |
| wb_val_i | input | WB_W | New base value for base write |
| log_idx_i | input | 4 | Logical register number to map |
| phys_idx_o | output | PI_W | Physical index of `log_idx_i` |
| window_base_o | output | WB_W | Current window base |
| window_start_o | output | NAREG/4 | Live-frame mask |
| exc_o | output | 4 | Exception code, 0 none |
| owb_o | output | WB_W | Base to save on overflow or underflow |
| excm_set_o | output | 1 | Request to set exception mode |
| sp_we_o | output | 1 | Stack pointer write request |
| sp_idx_o | output | 4 | Logical target of the stack write |
| sp_data_o | output | 32 | New stack pointer value |
| ret_valid_o | output | 1 | Return PC valid |
| ret_pc_o | output | 32 | Return target |

## Verification
Every command result (exception code, saved base, stack write, return PC) and the updated base and mask become visible one rising edge after the command is applied. The index mapping is combinational from the base register, so it is visible as soon as that edge has passed. The bench applies each command at a falling edge and reads all outputs at the following falling edge, half a cycle after the capturing edge and half a cycle before the next command is accepted. It then walks a state-carrying sequence in which each row's expected base and mask follow from the rows before it.

// File: rtl/wr_pkg.sv
package wr_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ENTRY   = 3'd1,
    OP_RETW    = 3'd2,
    OP_ROTW    = 3'd3,
    OP_WRWB    = 3'd4,
    OP_RESTORE = 3'd5,
    OP_MOVSP   = 3'd6
  } wr_op_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_ILLEGAL = 4'd1,
    EXC_OVF4    = 4'd2,
    EXC_OVF8    = 4'd3,
    EXC_OVF12   = 4'd4,
    EXC_UNF4    = 4'd5,
    EXC_UNF8    = 4'd6,
    EXC_UNF12   = 4'd7,
    EXC_ALLOCA  = 4'd8
  } wr_exc_e;

  localparam int DW = 32;
  localparam int SCAN_W = 5;  // groups above base inspected by entry
endpackage

// File: rtl/wr_map.sv
module wr_map #(
  parameter int WB_W = 3,
  parameter int PI_W = 5
) (
  input  logic [WB_W-1:0] wb_i,
  input  logic [3:0]      log_idx_i,
  output logic [PI_W-1:0] phys_idx_o
);
  // power-of-two file: truncation gives the wrap
  assign phys_idx_o = PI_W'({wb_i, 2'b00}) + PI_W'(log_idx_i);
endmodule

// File: rtl/wr_rot.sv
module wr_rot #(
  parameter int NGRP  = 8,
  parameter int WB_W  = 3,
  parameter int NOUT  = 5
) (
  input  logic [NGRP-1:0] ws_i,
  input  logic [WB_W-1:0] wb_i,
  output logic [NOUT-1:0] rot_o
);
  // rot_o[k] = ws[(wb + 1 + k) mod NGRP]
  for (genvar k = 0; k < NOUT; k++) begin : g_tap
    localparam logic [WB_W-1:0] OFS = WB_W'(k + 1);
    logic [WB_W-1:0] sel;
    assign sel      = wb_i + OFS;
    assign rot_o[k] = ws_i[sel];
  end
endmodule

// File: rtl/wr_scan.sv
module wr_scan
  import wr_pkg::*;
(
  input  logic [SCAN_W-1:0] rot_i,
  input  logic [1:0]        callinc_i,
  output logic              ovf_o,
  output logic [1:0]        step_o,
  output logic [3:0]        kind_o
);
  logic [2:0] span;
  logic       d0, d1;

  always_comb begin
    unique case (callinc_i)
      2'd0:    span = 3'b000;
      2'd1:    span = 3'b001;
      2'd2:    span = 3'b011;
      default: span = 3'b111;
    endcase
    ovf_o = |(rot_i[2:0] & span);

    if (rot_i[0])      step_o = 2'd1;
    else if (rot_i[1]) step_o = 2'd2;
    else               step_o = 2'd3;

    unique case (step_o)
      2'd1:    begin d0 = rot_i[1]; d1 = rot_i[2]; end
      2'd2:    begin d0 = rot_i[2]; d1 = rot_i[3]; end
      default: begin d0 = rot_i[3]; d1 = rot_i[4]; end
    endcase

    if (d0)      kind_o = EXC_OVF4;
    else if (d1) kind_o = EXC_OVF8;
    else         kind_o = EXC_OVF12;
  end
endmodule

// File: rtl/wreg_ctrl.sv
module wreg_ctrl
  import wr_pkg::*;
#(
  parameter  int NAREG = 32,
  localparam int NGRP  = NAREG / 4,
  localparam int WB_W  = $clog2(NGRP),
  localparam int PI_W  = $clog2(NAREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic            ps_woe_i,
  input  logic            ps_excm_i,
  input  logic [WB_W-1:0] ps_owb_i,
  input  logic [1:0]      callinc_i,
  input  logic [3:0]      spec_i,
  input  logic [DW-1:0]   imm_i,
  input  logic [DW-1:0]   sp_i,
  input  logic [DW-1:0]   a0_i,
  input  logic [1:0]      pc_hi_i,
  input  logic [3:0]      rot_i,
  input  logic [WB_W-1:0] wb_val_i,
  input  logic [3:0]      log_idx_i,
  output logic [PI_W-1:0] phys_idx_o,
  output logic [WB_W-1:0] window_base_o,
  output logic [NGRP-1:0] window_start_o,
  output logic [3:0]      exc_o,
  output logic [WB_W-1:0] owb_o,
  output logic            excm_set_o,
  output logic            sp_we_o,
  output logic [3:0]      sp_idx_o,
  output logic [DW-1:0]   sp_data_o,
  output logic            ret_valid_o,
  output logic [DW-1:0]   ret_pc_o
);
  logic [WB_W-1:0] wb_q, wb_d;
  logic [NGRP-1:0] ws_q, ws_d;
  logic [3:0]      exc_d;
  logic [WB_W-1:0] owb_d;
  logic            excm_d, we_d, rv_d;
  logic [3:0]      idx_d;
  logic [DW-1:0]   data_d, rpc_d;

  logic [SCAN_W-1:0] rot;
  logic              ovf;
  logic [1:0]        step;
  logic [3:0]        ovf_kind;

  wr_map #(.WB_W(WB_W), .PI_W(PI_W)) u_map (
    .wb_i(wb_q), .log_idx_i(log_idx_i), .phys_idx_o(phys_idx_o)
  );

  wr_rot #(.NGRP(NGRP), .WB_W(WB_W), .NOUT(SCAN_W)) u_rot (
    .ws_i(ws_q), .wb_i(wb_q), .rot_o(rot)
  );

  wr_scan u_scan (
    .rot_i(rot), .callinc_i(callinc_i),
    .ovf_o(ovf), .step_o(step), .kind_o(ovf_kind)
  );

  // groups below base, used by return and stack-move check
  logic            below1, below2, below3;
  logic [1:0]      ret_n, ret_m;
  logic            ret_bad, ent_bad;
  logic [WB_W-1:0] wb_ent, wb_ret, rot_amt;

  assign below1  = ws_q[wb_q - WB_W'(1)];
  assign below2  = ws_q[wb_q - WB_W'(2)];
  assign below3  = ws_q[wb_q - WB_W'(3)];
  assign ret_n   = a0_i[31:30];
  assign ret_m   = below1 ? 2'd1 : below2 ? 2'd2 : below3 ? 2'd3 : 2'd0;
  assign ret_bad = (ret_n == 2'd0) || (ret_m != 2'd0 && ret_m != ret_n) ||
                   !ps_woe_i || ps_excm_i;
  assign ent_bad = (spec_i > 4'd3) || !ps_woe_i || ps_excm_i;
  assign wb_ent  = wb_q + WB_W'(callinc_i);
  assign wb_ret  = wb_q - WB_W'(ret_n);
  assign rot_amt = WB_W'({{4{rot_i[3]}}, rot_i});

  always_comb begin
    wb_d   = wb_q;
    ws_d   = ws_q;
    exc_d  = EXC_NONE;
    owb_d  = wb_q;
    excm_d = 1'b0;
    we_d   = 1'b0;
    idx_d  = 4'd0;
    data_d = '0;
    rv_d   = 1'b0;
    rpc_d  = '0;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_ENTRY: begin
          if (ent_bad) begin
            exc_d = EXC_ILLEGAL;
          end else if (ovf) begin
            wb_d   = wb_q + WB_W'(step);
            exc_d  = ovf_kind;
            excm_d = 1'b1;
          end else begin
            we_d         = 1'b1;
            idx_d        = {callinc_i, spec_i[1:0]};
            data_d       = sp_i - imm_i;
            wb_d         = wb_ent;
            ws_d[wb_ent] = 1'b1;
          end
        end
        OP_RETW: begin
          if (ret_bad) begin
            exc_d = EXC_ILLEGAL;
          end else begin
            wb_d = wb_ret;
            if (ws_q[wb_ret]) begin
              ws_d[wb_q] = 1'b0;
              rv_d       = 1'b1;
              rpc_d      = {pc_hi_i, a0_i[29:0]};
            end else begin
              excm_d = 1'b1;
              unique case (ret_n)
                2'd1:    exc_d = EXC_UNF4;
                2'd2:    exc_d = EXC_UNF8;
                default: exc_d = EXC_UNF12;
              endcase
            end
          end
        end
        OP_ROTW:    wb_d = wb_q + rot_amt;
        OP_WRWB:    wb_d = wb_val_i;
        OP_RESTORE: wb_d = ps_owb_i;
        OP_MOVSP:   if (!(below1 || below2 || below3)) exc_d = EXC_ALLOCA;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q        <= '0;
      ws_q        <= NGRP'(1);
      exc_o       <= EXC_NONE;
      owb_o       <= '0;
      excm_set_o  <= 1'b0;
      sp_we_o     <= 1'b0;
      sp_idx_o    <= 4'd0;
      sp_data_o   <= '0;
      ret_valid_o <= 1'b0;
      ret_pc_o    <= '0;
    end else begin
      wb_q        <= wb_d;
      ws_q        <= ws_d;
      exc_o       <= exc_d;
      owb_o       <= owb_d;
      excm_set_o  <= excm_d;
      sp_we_o     <= we_d;
      sp_idx_o    <= idx_d;
      sp_data_o   <= data_d;
      ret_valid_o <= rv_d;
      ret_pc_o    <= rpc_d;
    end
  end

  assign window_base_o  = wb_q;
  assign window_start_o = ws_q;

  // R11
  single_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({exc_o != 4'd0, sp_we_o, ret_valid_o}) <= 1);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(wb_q) && $stable(ws_q) && exc_o == 4'd0);

  // R4
  entry_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> ws_q[wb_q]);

  // R5
  excm_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excm_set_o |-> (exc_o >= 4'd2 && exc_o <= 4'd7));

  // R7
  ret_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> ret_pc_o[31:30] == $past(pc_hi_i) && !ws_q[$past(wb_q)]);
endmodule

// File: tb/wreg_ctrl_bench.sv
`timescale 1ns/1ps
module wreg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        woe = 1'b0, excm = 1'b0;
  logic [2:0]  owb_in = '0;
  logic [1:0]  ci = '0;
  logic [3:0]  spec = '0;
  logic [31:0] imm = '0, sp = '0, a0 = '0;
  logic [1:0]  pc_hi = '0;
  logic [3:0]  rot = '0;
  logic [2:0]  wbv = '0;
  logic [3:0]  log_idx = '0;
  logic [4:0]  phys;
  logic [2:0]  wb;
  logic [7:0]  ws;
  logic [3:0]  exc;
  logic [2:0]  owb;
  logic        excm_set, sp_we, rv;
  logic [3:0]  sp_idx;
  logic [31:0] sp_data, rpc;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wreg_ctrl u_wreg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .ps_woe_i(woe), .ps_excm_i(excm), .ps_owb_i(owb_in), .callinc_i(ci),
    .spec_i(spec), .imm_i(imm), .sp_i(sp), .a0_i(a0), .pc_hi_i(pc_hi),
    .rot_i(rot), .wb_val_i(wbv), .log_idx_i(log_idx), .phys_idx_o(phys),
    .window_base_o(wb), .window_start_o(ws), .exc_o(exc), .owb_o(owb),
    .excm_set_o(excm_set), .sp_we_o(sp_we), .sp_idx_o(sp_idx),
    .sp_data_o(sp_data), .ret_valid_o(rv), .ret_pc_o(rpc)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op;
    logic        woe, excm;
    logic [2:0]  owb;
    logic [1:0]  ci;
    logic [3:0]  s;
    logic [31:0] imm, sp, a0;
    logic [1:0]  pch;
    logic [3:0]  rot;
    logic [2:0]  wbv;
    logic [3:0]  e_exc;
    logic [2:0]  e_wb;
    logic [7:0]  e_ws;
    logic        e_we;
    logic [3:0]  e_idx;
    logic [31:0] e_data;
    logic        e_rv;
    logic [31:0] e_rpc;
    logic [2:0]  e_owb;
  } vec_t;

  localparam int NV = 30;
  // rq op woe excm owb ci s imm sp a0 pch rot wbv | exc wb ws we idx data rv rpc owb
  localparam vec_t VEC [NV] = '{
    '{4, 1,1,0,0, 1,1, 'h10,'h1000,0, 0,0,0,  0,1,'h03,1,5,'hFF0,0,0,0},          // R4
    '{4, 1,1,0,0, 2,1, 'h20,'hFF0,0,  0,0,0,  0,3,'h0B,1,9,'hFD0,0,0,0},           // R4
    '{4, 1,1,0,0, 3,2, 'h4,'h100,0,   0,0,0,  0,6,'h4B,1,14,'hFC,0,0,0},           // R4
    '{5, 1,1,0,0, 3,1, 0,0,0,         0,0,0,  2,0,'h4B,0,0,0,0,0,6},               // R5 overflow 4
    '{10,5,1,0,6, 0,0, 0,0,0,         0,0,0,  0,6,'h4B,0,0,0,0,0,0},               // R10 restore
    '{7, 2,1,0,0, 0,0, 0,0,'hC0000100,1,0,0,  0,3,'h0B,0,0,0,1,'h40000100,0},      // R7
    '{6, 2,1,0,0, 0,0, 0,0,'h40000000,0,0,0,  1,3,'h0B,0,0,0,0,0,0},               // R6 m!=n
    '{6, 2,1,0,0, 0,0, 0,0,'h10,      0,0,0,  1,3,'h0B,0,0,0,0,0,0},               // R6 n=0
    '{6, 2,0,0,0, 0,0, 0,0,'h80000200,0,0,0,  1,3,'h0B,0,0,0,0,0,0},               // R6 woe clear
    '{7, 2,1,0,0, 0,0, 0,0,'h80000200,3,0,0,  0,1,'h03,0,0,0,1,'hC0000200,0},      // R7
    '{9, 6,1,0,0, 0,0, 0,0,0,         0,0,0,  0,1,'h03,0,0,0,0,0,0},               // R9 no alloca
    '{2, 4,1,0,0, 0,0, 0,0,0,         0,0,5,  0,5,'h03,0,0,0,0,0,0},               // R2 base write
    '{9, 6,1,0,0, 0,0, 0,0,0,         0,0,0,  8,5,'h03,0,0,0,0,0,0},               // R9 alloca
    '{8, 2,1,0,0, 0,0, 0,0,'h40000000,0,0,0,  5,4,'h03,0,0,0,0,0,5},               // R8 underflow 4
    '{10,3,1,0,0, 0,0, 0,0,0,         0,'hE,0,0,2,'h03,0,0,0,0,0,0},               // R10 rotate -2
    '{6, 2,1,0,0, 0,0, 0,0,'hC0000000,0,0,0,  1,2,'h03,0,0,0,0,0,0},               // R6
    '{3, 1,1,1,0, 1,1, 0,0,0,         0,0,0,  1,2,'h03,0,0,0,0,0,0},               // R3 excm set
    '{3, 1,1,0,0, 1,4, 0,0,0,         0,0,0,  1,2,'h03,0,0,0,0,0,0},               // R3 spec>3
    '{10,3,1,0,0, 0,0, 0,0,0,         0,7,0,  0,1,'h03,0,0,0,0,0,0},               // R10 rotate wraps
    '{2, 4,1,0,0, 0,0, 0,0,0,         0,0,0,  0,0,'h03,0,0,0,0,0,0},               // R2
    '{8, 2,1,0,0, 0,0, 0,0,'h80000000,0,0,0,  6,6,'h03,0,0,0,0,0,0},               // R8 underflow 8
    '{2, 4,1,0,0, 0,0, 0,0,0,         0,0,0,  0,0,'h03,0,0,0,0,0,0},               // R2
    '{8, 2,1,0,0, 0,0, 0,0,'hC0000000,0,0,0,  7,5,'h03,0,0,0,0,0,0},               // R8 underflow 12
    '{2, 4,1,0,0, 0,0, 0,0,0,         0,0,0,  0,0,'h03,0,0,0,0,0,0},               // R2
    '{5, 1,1,0,0, 1,0, 0,0,0,         0,0,0,  4,1,'h03,0,0,0,0,0,0},               // R5 overflow 12
    '{4, 1,1,0,0, 2,0, 'h8,'h80,0,    0,0,0,  0,3,'h0B,1,8,'h78,0,0,0},            // R4
    '{2, 4,1,0,0, 0,0, 0,0,0,         0,0,0,  0,0,'h0B,0,0,0,0,0,0},               // R2
    '{5, 1,1,0,0, 1,3, 0,0,0,         0,0,0,  3,1,'h0B,0,0,0,0,0,0},               // R5 overflow 8
    '{4, 1,1,0,0, 0,0, 'h4,'h40,0,    0,0,0,  0,1,'h0B,1,0,'h3C,0,0,0},            // R4 callinc 0
    '{11,0,1,0,0, 0,0, 0,0,0,         0,0,0,  0,1,'h0B,0,0,0,0,0,0}                // R11 no-op code
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_outs(input int rq);
    chk(rq, "exc", 32'(exc), 0);
    chk(rq, "sp_we", 32'(sp_we), 0);
    chk(rq, "ret_valid", 32'(rv), 0);
    chk(rq, "excm_set", 32'(excm_set), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "wb", 32'(wb), 0);
    chk(1, "ws", 32'(ws), 32'h01);
    idle_outs(1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cmd_valid = 1'b1;
      cmd_op = VEC[i].op;  woe = VEC[i].woe;  excm = VEC[i].excm;
      owb_in = VEC[i].owb; ci = VEC[i].ci;    spec = VEC[i].s;
      imm = VEC[i].imm;    sp = VEC[i].sp;    a0 = VEC[i].a0;
      pc_hi = VEC[i].pch;  rot = VEC[i].rot;  wbv = VEC[i].wbv;
      @(negedge clk);
      chk(VEC[i].rq, $sformatf("row%0d exc", i), 32'(exc), 32'(VEC[i].e_exc));
      chk(VEC[i].rq, $sformatf("row%0d wb", i), 32'(wb), 32'(VEC[i].e_wb));
      chk(VEC[i].rq, $sformatf("row%0d ws", i), 32'(ws), 32'(VEC[i].e_ws));
      chk(VEC[i].rq, $sformatf("row%0d sp_we", i), 32'(sp_we), 32'(VEC[i].e_we));
      if (VEC[i].e_we) begin
        chk(VEC[i].rq, $sformatf("row%0d sp_idx", i), 32'(sp_idx), 32'(VEC[i].e_idx));
        chk(VEC[i].rq, $sformatf("row%0d sp_data", i), sp_data, VEC[i].e_data);
      end
      chk(VEC[i].rq, $sformatf("row%0d ret_valid", i), 32'(rv), 32'(VEC[i].e_rv));
      if (VEC[i].e_rv)
        chk(VEC[i].rq, $sformatf("row%0d ret_pc", i), rpc, VEC[i].e_rpc);
      if (VEC[i].e_exc >= 2 && VEC[i].e_exc <= 7) begin
        chk(VEC[i].rq, $sformatf("row%0d owb", i), 32'(owb), 32'(VEC[i].e_owb));
        chk(VEC[i].rq, $sformatf("row%0d excm_set", i), 32'(excm_set), 1);
      end else begin
        chk(VEC[i].rq, $sformatf("row%0d excm_set", i), 32'(excm_set), 0);
      end
    end

    // R11 idle cycle: no state change, outputs drop
    cmd_valid = 1'b0;
    cmd_op = 3'd3; rot = 4'd2;
    @(negedge clk);
    chk(11, "idle wb", 32'(wb), 1);
    chk(11, "idle ws", 32'(ws), 32'h0B);
    idle_outs(11);

    // R2 mapping with base 1
    log_idx = 4'd15;
    #1;
    chk(2, "phys wb1 l15", 32'(phys), 19);

    // R2 mapping wraps with base 7
    cmd_valid = 1'b1; cmd_op = 3'd4; wbv = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    log_idx = 4'd5;
    #1;
    chk(2, "phys wb7 l5", 32'(phys), 1);
    log_idx = 4'd0;
    #1;
    chk(2, "phys wb7 l0", 32'(phys), 28);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1, "rst wb", 32'(wb), 0);
    chk(1, "rst ws", 32'(ws), 32'h01);
    idle_outs(1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule